// File: doc/BRIEF.md
# Rotated Immediate Codec

This block converts between a 32-bit constant and the compact 12-bit immediate form used by a processor's data-processing instructions. The short form holds an 8-bit payload and a 4-bit rotation selector. The constant it stands for is the payload, zero-extended to 32 bits and rotated right by twice the selector. Because of this, only constants that are a single byte placed at an even rotation can be expressed.

The decode path is purely combinational. It expands a 12-bit field into the 32-bit constant. The encode path reports whether a candidate constant can be expressed and, if it can, returns the payload and the selector. When several encodings exist, it returns the one with the smallest selector. The encode path is offered in two forms:

- A single-cycle parallel search that tries all 16 rotations at once.
- A sequential search. It captures the candidate on a start pulse, tries one rotation per clock, and signals completion with a one-cycle done pulse. It is meant for callers that prefer a small datapath to low latency.

An assembler-side checker or an instruction generator would use the encode path. An instruction decode stage would use the decode path.

Top module: `rotimm_codec`

## Requirements
- R1: `dec_value_o` equals `{24'b0, dec_field_i[7:0]}` rotated right by `2*dec_field_i[11:8]` bits. The field layout is payload in bits 7:0 and selector in bits 11:8.
- R2: `comb_ok_o` is 1 exactly when some selector r in 0..15 exists such that rotating `enc_value_i` left by 2r leaves bits 31:8 zero. `comb_byte_o` is then the low byte of that rotated value, and `comb_rot_o` is r. Examples:
  - 256 gives (1, 12).
  - 384 gives (6, 13).
  - 484 gives (121, 15).
  - 0x06000000 gives (6, 4).
  - 255 gives (255, 0).
- R3: When more than one selector fits, the smallest one is reported. For example, 0 gives (0, 0) and 0x40000000 gives (1, 1).
- R4: Constants that fit no even rotation are flagged with ok = 0, and byte and selector then read 0. Examples: 511, 0x06010000 and 370.
- R5: In the sequential path, `seq_start_i` high while idle is captured at a clock edge k, together with `enc_value_i`. `seq_done_o` is then high for exactly one cycle, following edge k+1+r for a result with selector r, or following edge k+16 for an invalid value. `seq_busy_o` is high from edge k until done.
- R6: The sequential result (ok, byte, selector) equals the parallel result for the captured value. It holds until the next accepted start.
- R7: `seq_start_i` is ignored while `seq_busy_o` is high. Neither the pending result nor its timing changes.
- R8: After a synchronous active-low reset, `seq_busy_o`, `seq_done_o`, `seq_ok_o`, `seq_byte_o` and `seq_rot_o` are all 0.
- R9: Applying any valid encoder output `{rot, byte}` to the decode path reproduces the encoded 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_field_i | input | 12 | Immediate field to expand (selector 11:8, payload 7:0) |
| dec_value_o | output | 32 | Expanded constant |
| enc_value_i | input | 32 | Candidate constant for both encode paths |
| comb_ok_o | output | 1 | Parallel search: constant is encodable |
| comb_byte_o | output | 8 | Parallel search: payload |
| comb_rot_o | output | 4 | Parallel search: rotation selector |
| seq_start_i | input | 1 | Start the sequential search (taken only when idle) |
| seq_busy_o | output | 1 | Sequential search in progress |
| seq_done_o | output | 1 | One-cycle completion pulse |
| seq_ok_o | output | 1 | Sequential search: constant is encodable |
| seq_byte_o | output | 8 | Sequential search: payload |
| seq_rot_o | output | 4 | Sequential search: rotation selector |

## Verification
Two situations are hard to reach from the ports:

- Constants that fit several rotations. These are needed to show the lowest-selector preference. The stimulus builds them on purpose from payloads with zero low bit pairs, for example 1, 4 and 16 placed at several rotations.
- A start pulse that arrives while a search is still running. The only way to show it is ignored is the timing of done and the result it delivers. The bench therefore launches a 16-cycle invalid search and raises start mid-way with a different, quickly encodable value. It then checks that the first value's result and done timing are kept, and that no second done follows.

Odd-aligned single-byte patterns such as 370 are applied to separate a byte-width test from an even-rotation test.

// File: rtl/rotimm_pkg.sv
// Package: shared widths and rotation helpers for the rotated immediate codec.
// Assumes DATA_W is a multiple of the rotation step and wider than BYTE_W.
package rotimm_pkg;
    localparam int DATA_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int ROT_W   = 4;
    localparam int NUM_ROT = 1 << ROT_W;
    localparam int SHAMT_W = ROT_W + 1;
    localparam int FIELD_W = ROT_W + BYTE_W;

    // Rotate left by amt bits using a doubled word.
    function automatic logic [DATA_W-1:0] rot_left(input logic [DATA_W-1:0] v,
                                                   input logic [SHAMT_W-1:0] amt);
        logic [2*DATA_W-1:0] dbl;
        dbl = {v, v} << amt;
        return dbl[2*DATA_W-1:DATA_W];
    endfunction

    // Rotate right by amt bits using a doubled word.
    function automatic logic [DATA_W-1:0] rot_right(input logic [DATA_W-1:0] v,
                                                    input logic [SHAMT_W-1:0] amt);
        logic [2*DATA_W-1:0] dbl;
        dbl = {v, v} >> amt;
        return dbl[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/rotimm_expand.sv
// Module: rotimm_expand
// Expands a payload/selector pair into the full constant (payload rotated
// right by twice the selector). Purely combinational.
module rotimm_expand
    import rotimm_pkg::*;
(
    input  logic [BYTE_W-1:0] payload_i,
    input  logic [ROT_W-1:0]  sel_i,
    output logic [DATA_W-1:0] value_o
);
    // Zero-extend the payload and rotate by the even amount.
    always_comb begin
        value_o = rot_right({{(DATA_W-BYTE_W){1'b0}}, payload_i}, {sel_i, 1'b0});
    end
endmodule

// File: rtl/rotimm_fit.sv
// Module: rotimm_fit
// Tests one rotation selector: the value rotated left by twice the selector
// must leave only the low byte populated. Purely combinational.
module rotimm_fit
    import rotimm_pkg::*;
(
    input  logic [DATA_W-1:0] value_i,
    input  logic [ROT_W-1:0]  sel_i,
    output logic              fits_o,
    output logic [BYTE_W-1:0] payload_o
);
    logic [DATA_W-1:0] undone;

    // Undo the candidate rotation and inspect the upper bits.
    always_comb begin
        undone    = rot_left(value_i, {sel_i, 1'b0});
        fits_o    = (undone[DATA_W-1:BYTE_W] == '0);
        payload_o = undone[BYTE_W-1:0];
    end
endmodule

// File: rtl/rotimm_par_search.sv
// Module: rotimm_par_search
// Single-cycle encoder: one fit tester per selector, then a priority pick of
// the lowest fitting selector. Outputs read zero when nothing fits.
module rotimm_par_search
    import rotimm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] value_i,
    output logic              ok_o,
    output logic [BYTE_W-1:0] payload_o,
    output logic [ROT_W-1:0]  sel_o
);
    logic [NUM_ROT-1:0] fit_vec;
    logic [BYTE_W-1:0]  pay_arr [NUM_ROT];

    for (genvar g = 0; g < NUM_ROT; g++) begin : g_try
        rotimm_fit u_fit (
            .value_i  (value_i),
            .sel_i    (ROT_W'(g)),
            .fits_o   (fit_vec[g]),
            .payload_o(pay_arr[g])
        );
    end

    // Priority select: scanning downward lets the lowest selector win.
    always_comb begin
        ok_o      = 1'b0;
        payload_o = '0;
        sel_o     = '0;
        for (int i = NUM_ROT - 1; i >= 0; i--) begin
            if (fit_vec[i]) begin
                ok_o      = 1'b1;
                payload_o = pay_arr[i];
                sel_o     = ROT_W'(i);
            end
        end
    end

    assert_invalid_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_o |-> (payload_o == '0 && sel_o == '0 && fit_vec == '0));

    assert_zero_encodes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (value_i == '0) |-> (ok_o && sel_o == '0 && payload_o == '0));
endmodule

// File: rtl/rotimm_seq_search.sv
// Module: rotimm_seq_search
// Multi-cycle encoder: captures the value on start (only when idle), tests
// selector 0,1,...,15 on successive cycles, stops at the first fit and pulses
// done. Result registers hold until the next accepted start.
module rotimm_seq_search
    import rotimm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] value_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              ok_o,
    output logic [BYTE_W-1:0] payload_o,
    output logic [ROT_W-1:0]  sel_o
);
    localparam logic [ROT_W-1:0] LAST_SEL = ROT_W'(NUM_ROT - 1);

    logic [DATA_W-1:0] val_q;
    logic [ROT_W-1:0]  cnt_q;
    logic              try_fit;
    logic [BYTE_W-1:0] try_pay;
    logic [DATA_W-1:0] check_val;

    rotimm_fit u_fit (
        .value_i  (val_q),
        .sel_i    (cnt_q),
        .fits_o   (try_fit),
        .payload_o(try_pay)
    );

    rotimm_expand u_check (
        .payload_i(payload_o),
        .sel_i    (sel_o),
        .value_o  (check_val)
    );

    // Search state machine: capture, step one selector per cycle, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o    <= 1'b0;
            done_o    <= 1'b0;
            ok_o      <= 1'b0;
            payload_o <= '0;
            sel_o     <= '0;
            cnt_q     <= '0;
            val_q     <= '0;
        end else begin
            done_o <= 1'b0;
            if (!busy_o) begin
                if (start_i) begin
                    busy_o    <= 1'b1;
                    cnt_q     <= '0;
                    val_q     <= value_i;
                    ok_o      <= 1'b0;
                    payload_o <= '0;
                    sel_o     <= '0;
                end
            end else if (try_fit) begin
                busy_o    <= 1'b0;
                done_o    <= 1'b1;
                ok_o      <= 1'b1;
                payload_o <= try_pay;
                sel_o     <= cnt_q;
            end else if (cnt_q == LAST_SEL) begin
                busy_o <= 1'b0;
                done_o <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_hold_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(val_q));

    assert_result_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ok_o) |-> (check_val == val_q));
endmodule

// File: rtl/rotimm_codec.sv
// Module: rotimm_codec (top)
// Rotated immediate codec: combinational decode, single-cycle parallel
// encode and a sequential one-selector-per-cycle encode sharing the candidate
// input. Synchronous active-low reset applies to the sequential path only.
module rotimm_codec
    import rotimm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FIELD_W-1:0]  dec_field_i,
    output logic [DATA_W-1:0]   dec_value_o,
    input  logic [DATA_W-1:0]   enc_value_i,
    output logic                comb_ok_o,
    output logic [BYTE_W-1:0]   comb_byte_o,
    output logic [ROT_W-1:0]    comb_rot_o,
    input  logic                seq_start_i,
    output logic                seq_busy_o,
    output logic                seq_done_o,
    output logic                seq_ok_o,
    output logic [BYTE_W-1:0]   seq_byte_o,
    output logic [ROT_W-1:0]    seq_rot_o
);
    logic [DATA_W-1:0] roundtrip;

    rotimm_expand u_dec (
        .payload_i(dec_field_i[BYTE_W-1:0]),
        .sel_i    (dec_field_i[FIELD_W-1:BYTE_W]),
        .value_o  (dec_value_o)
    );

    rotimm_par_search u_par (
        .clk      (clk),
        .rst_n    (rst_n),
        .value_i  (enc_value_i),
        .ok_o     (comb_ok_o),
        .payload_o(comb_byte_o),
        .sel_o    (comb_rot_o)
    );

    rotimm_seq_search u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (seq_start_i),
        .value_i  (enc_value_i),
        .busy_o   (seq_busy_o),
        .done_o   (seq_done_o),
        .ok_o     (seq_ok_o),
        .payload_o(seq_byte_o),
        .sel_o    (seq_rot_o)
    );

    // Independent expander fed from the encoder, used only for checking.
    rotimm_expand u_rt (
        .payload_i(comb_byte_o),
        .sel_i    (comb_rot_o),
        .value_o  (roundtrip)
    );

    assert_roundtrip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        comb_ok_o |-> (roundtrip == enc_value_i));
endmodule

// File: tb/rotimm_codec_tb_top.sv
// Bench for rotimm_codec: behavioural reference model, per-clock comparison of
// the combinational paths, directed sequential searches with cycle counting.
module rotimm_codec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] dec_field = '0;
    logic [31:0] dec_value;
    logic [31:0] enc_value = '0;
    logic        comb_ok;
    logic [7:0]  comb_byte;
    logic [3:0]  comb_rot;
    logic        seq_start = 1'b0;
    logic        seq_busy, seq_done, seq_ok;
    logic [7:0]  seq_byte;
    logic [3:0]  seq_rot;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rotimm_codec dut_i (
        .clk(clk), .rst_n(rst_n),
        .dec_field_i(dec_field), .dec_value_o(dec_value),
        .enc_value_i(enc_value),
        .comb_ok_o(comb_ok), .comb_byte_o(comb_byte), .comb_rot_o(comb_rot),
        .seq_start_i(seq_start), .seq_busy_o(seq_busy), .seq_done_o(seq_done),
        .seq_ok_o(seq_ok), .seq_byte_o(seq_byte), .seq_rot_o(seq_rot)
    );

    // Reference: rotate right by shifting, in plain integer arithmetic.
    function automatic logic [31:0] ref_ror(input logic [31:0] v, input int sh);
        if (sh == 0) return v;
        return (v >> sh) | (v << (32 - sh));
    endfunction

    // Reference encoder: scan selectors from 0 and stop at the first match.
    function automatic void ref_enc(input logic [31:0] v, output bit ok,
                                    output logic [7:0] b, output logic [3:0] r);
        ok = 0; b = 0; r = 0;
        for (int s = 0; s < 16; s++) begin
            for (int n = 0; n < 256; n++) begin
                if (!ok && ref_ror(32'(n), 2 * s) == v) begin
                    ok = 1; b = 8'(n); r = 4'(s);
                end
            end
        end
    endfunction

    task automatic check(input bit cond, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison of decode and parallel encode (R1, R2, R3, R4).
    always @(negedge clk) begin
        if (rst_n) begin
            bit ok_e; logic [7:0] b_e; logic [3:0] r_e;
            check(dec_value == ref_ror({24'b0, dec_field[7:0]}, 2 * int'(dec_field[11:8])),
                  "R1", "decode", dec_value,
                  ref_ror({24'b0, dec_field[7:0]}, 2 * int'(dec_field[11:8])));
            ref_enc(enc_value, ok_e, b_e, r_e);
            check({comb_ok, comb_byte, comb_rot} == {ok_e, b_e, r_e}, "R2/R3/R4",
                  "parallel encode {ok,byte,rot}", 32'({comb_ok, comb_byte, comb_rot}),
                  32'({ok_e, b_e, r_e}));
        end
    end

    task automatic apply(input logic [31:0] v, input logic [11:0] f);
        @(posedge clk); #1;
        enc_value = v;
        dec_field = f;
    endtask

    // Directed parallel-encode expectation, labelled by requirement.
    task automatic expect_enc(input logic [31:0] v, input bit ok, input logic [7:0] b,
                              input logic [3:0] r, input string req);
        apply(v, dec_field);
        @(negedge clk);
        check({comb_ok, comb_byte, comb_rot} == {ok, b, r}, req, "directed encode",
              32'({comb_ok, comb_byte, comb_rot}), 32'({ok, b, r}));
    endtask

    // Feed the encoder output back through the decoder (R9).
    task automatic roundtrip(input logic [31:0] v);
        apply(v, dec_field);
        @(negedge clk);
        if (comb_ok) begin
            apply(v, {comb_rot, comb_byte});
            @(negedge clk);
            check(dec_value == v, "R9", "roundtrip", dec_value, v);
        end
    endtask

    // Sequential search with done-cycle counting (R5, R6).
    task automatic seq_run(input logic [31:0] v);
        bit ok_e; logic [7:0] b_e; logic [3:0] r_e;
        int seen, expc;
        ref_enc(v, ok_e, b_e, r_e);
        expc = ok_e ? int'(r_e) + 1 : 16;
        seen = 0;
        @(posedge clk); #1;
        enc_value = v;
        seq_start = 1'b1;
        @(posedge clk); #1;
        seq_start = 1'b0;
        for (int i = 1; i <= 18; i++) begin
            @(posedge clk); @(negedge clk);
            if (seq_done) begin
                if (seen == 0) begin
                    check(i == expc, "R5", "done cycle", 32'(i), 32'(expc));
                end else begin
                    check(1'b0, "R5", "extra done pulse", 32'(i), 32'(0));
                end
                seen++;
            end else if (i < expc) begin
                check(seq_busy, "R5", "busy while searching", 32'(seq_busy), 32'(1));
            end
        end
        check(seen == 1, "R5", "done count", 32'(seen), 32'(1));
        check({seq_ok, seq_byte, seq_rot} == {ok_e, b_e, r_e}, "R6", "sequential result",
              32'({seq_ok, seq_byte, seq_rot}), 32'({ok_e, b_e, r_e}));
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({seq_busy, seq_done, seq_ok, seq_byte, seq_rot} == '0, "R8", "reset state",
              32'({seq_busy, seq_done, seq_ok, seq_byte, seq_rot}), 32'(0));
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R2 directed encodings
        expect_enc(32'd256,       1, 8'd1,   4'd12, "R2");
        expect_enc(32'd384,       1, 8'd6,   4'd13, "R2");
        expect_enc(32'd484,       1, 8'd121, 4'd15, "R2");
        expect_enc(32'h0600_0000, 1, 8'd6,   4'd4,  "R2");
        expect_enc(32'd255,       1, 8'd255, 4'd0,  "R2");
        // R3 smallest selector
        expect_enc(32'd0,         1, 8'd0,   4'd0,  "R3");
        expect_enc(32'h4000_0000, 1, 8'd1,   4'd1,  "R3");
        expect_enc(32'h0000_0010, 1, 8'd16,  4'd0,  "R3");
        // R4 invalid constants
        expect_enc(32'd511,       0, 8'd0,   4'd0,  "R4");
        expect_enc(32'h0601_0000, 0, 8'd0,   4'd0,  "R4");
        expect_enc(32'd370,       0, 8'd0,   4'd0,  "R4");

        // R1 decode sweep over every selector with varied payloads
        for (int s = 0; s < 16; s++) apply(32'd0, {4'(s), 8'(8'hA5 ^ 8'(s * 37))});

        // R9 and R2: constructed valid values plus pseudo-random values
        lfsr = 32'hACE1_1234;
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            roundtrip(ref_ror({24'b0, lfsr[7:0]}, 2 * int'(lfsr[11:8])));
            apply(lfsr, lfsr[19:8]);
        end

        // R5/R6 sequential searches
        seq_run(32'd255);
        seq_run(32'd256);
        seq_run(32'd484);
        seq_run(32'h4000_0000);
        seq_run(32'd370);
        seq_run(32'd0);

        // R7: start raised mid-search with a fast-encodable value is ignored
        @(posedge clk); #1;
        enc_value = 32'd511;
        seq_start = 1'b1;
        @(posedge clk); #1;
        seq_start = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        enc_value = 32'd1;
        seq_start = 1'b1;
        @(posedge clk); #1;
        seq_start = 1'b0;
        begin
            int seen = 0;
            int at = 0;
            for (int i = 5; i <= 20; i++) begin
                @(posedge clk); @(negedge clk);
                if (seq_done) begin
                    seen++;
                    if (at == 0) at = i;
                end
            end
            check(at == 16, "R7", "done cycle kept", 32'(at), 32'(16));
            check(seen == 1, "R7", "single done", 32'(seen), 32'(1));
            check({seq_ok, seq_byte, seq_rot} == '0, "R7", "result of first value",
                  32'({seq_ok, seq_byte, seq_rot}), 32'(0));
            check(!seq_busy, "R7", "idle after", 32'(seq_busy), 32'(0));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule